// File: doc/BRIEF.md
# Cursor Overlay Compositor

This stage sits in a display pixel stream and places a small pointer image over the picture. Each incoming pixel carries the index of the display pipe it belongs to, its screen column and row, and its base colour. When the pixel falls inside the cursor box on the selected pipe, the stage replaces or mixes the base colour with the cursor image. Otherwise the base colour passes through unchanged. Each pixel appears at the output two clock cycles after it enters.

The cursor image is held in a local memory that is loaded through a simple write port. Each memory word holds one cursor pixel, and the box is stored row after row. Two image formats are supported. In the two-colour masked format, each pixel is transparent, foreground or background. In the alpha format, each pixel carries its own opacity and is mixed with the base colour.

The box is 32 or 64 pixels square. A packed position word sets its top-left corner. A select input attaches the cursor to one of two display pipes.

Top module: `cursor_overlay`

## Requirements
- R1: While rst_n is low, out_vld_o and out_pix_o are 0.
- R2: out_vld_o equals pix_vld_i as sampled two clock edges earlier.
- R3: cur_fmt_i = 0 (off) or 3 (reserved) makes every output pixel equal to its base colour.
- R4: A pixel whose pix_pipe_i differs from cur_pipe_i leaves with its base colour unchanged.
- R5: cur_big_i = 0 gives a 32x32 box and 1 gives 64x64. A pixel outside the box leaves unchanged, and this includes pixels beyond the end of the coordinate range, because the box does not wrap.
- R6: pos_i holds the box row origin in bits 31:16 and the column origin in bits 15:0. The pixel at (X+dx, Y+dy) uses image word dy*D+dx, where D is the box side.
- R7: With cur_fmt_i = 1 (masked), image word bit 1 is the mask and bit 0 is the colour. A clear mask gives the base colour. A set mask gives fg_i when bit 0 is 1 and bg_i when bit 0 is 0.
- R8: With cur_fmt_i = 2 (alpha), the image word holds alpha in bits 31:24 and red, green and blue in bits 23:16, 15:8 and 7:0. Each output channel is floor((A*C + (255-A)*B)/255), where C is the cursor channel and B is the base channel.
- R9: An image write with img_we_i high stores img_data_i at img_addr_i. The new word is seen by a pixel presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_fmt_i | input | 2 | Image format: 0 off, 1 masked, 2 alpha, 3 off |
| cur_big_i | input | 1 | Box size: 0 gives 32x32, 1 gives 64x64 |
| cur_pipe_i | input | 1 | Display pipe that shows the cursor |
| pos_i | input | 32 | Box origin: row in 31:16, column in 15:0 |
| fg_i | input | 24 | Foreground colour for the masked format |
| bg_i | input | 24 | Background colour for the masked format |
| img_we_i | input | 1 | Image memory write strobe |
| img_addr_i | input | 12 | Image memory word address |
| img_data_i | input | 32 | Image memory write data |
| pix_vld_i | input | 1 | Incoming pixel is valid |
| pix_pipe_i | input | 1 | Pipe of the incoming pixel |
| pix_x_i | input | 16 | Column of the incoming pixel |
| pix_y_i | input | 16 | Row of the incoming pixel |
| pix_base_i | input | 24 | Base colour of the incoming pixel |
| out_vld_o | output | 1 | Output pixel is valid |
| out_pix_o | output | 24 | Composited colour |

## Verification
The assertions assume two things about the inputs. First, the format and pipe inputs that apply to a pixel are the ones presented in the same cycle as that pixel. Second, every input holds a known value from the first clock edge onward, so a two-cycle look back after reset compares defined levels.

The bench drives every input at a fixed offset after the rising edge and gives all of them values before reset is released. It changes the cursor settings only between bursts of random pixels, and it keeps coordinates inside the 16-bit range. It also aims a share of the pixels just outside the box edges, so that the boundary rules are exercised and not only the interior.

// File: rtl/cur_pkg.sv
package cur_pkg;
    localparam int CHAN_W = 8;
    localparam int CHAN_N = 3;
    localparam int PIX_W  = CHAN_W * CHAN_N;
    localparam int IMG_W  = CHAN_W * (CHAN_N + 1);

    typedef enum logic [1:0] {
        FMT_OFF  = 2'd0,
        FMT_MONO = 2'd1,
        FMT_ARGB = 2'd2,
        FMT_RSV  = 2'd3
    } cur_fmt_e;

    typedef struct packed {
        logic             vld;
        logic             hit;
        cur_fmt_e         fmt;
        logic [PIX_W-1:0] base;
        logic [PIX_W-1:0] fg;
        logic [PIX_W-1:0] bg;
    } stg1_t;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] pix;
    } stg2_t;

    typedef struct packed {
        stg1_t s1;
        stg2_t s2;
    } ovl_state_t;
endpackage

// File: rtl/cur_img_ram.sv
module cur_img_ram #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4096,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             re_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        if (re_i) begin
            rdata_q <= mem_q[raddr_i];
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/cur_hit.sv
module cur_hit #(
    parameter int COORD_W = 16,
    parameter int MAX_DIM = 64,
    localparam int DW     = $clog2(MAX_DIM),
    localparam int AW     = 2 * DW
) (
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    input  logic [COORD_W-1:0] org_x_i,
    input  logic [COORD_W-1:0] org_y_i,
    input  logic               big_i,
    output logic               in_box_o,
    output logic [AW-1:0]      addr_o
);
    logic [COORD_W:0] dx, dy, side;

    always_comb begin
        side = big_i ? (COORD_W+1)'(MAX_DIM) : (COORD_W+1)'(MAX_DIM / 2);
        dx   = {1'b0, x_i} - {1'b0, org_x_i};
        dy   = {1'b0, y_i} - {1'b0, org_y_i};
        in_box_o = (x_i >= org_x_i) && (y_i >= org_y_i) && (dx < side) && (dy < side);
        if (big_i) begin
            addr_o = {dy[DW-1:0], dx[DW-1:0]};
        end else begin
            addr_o = {1'b0, dy[DW-2:0], dx[DW-2:0]};
        end
    end
endmodule

// File: rtl/cur_blend.sv
module cur_blend
    import cur_pkg::*;
(
    input  logic [CHAN_W-1:0] alpha_i,
    input  logic [PIX_W-1:0]  fore_i,
    input  logic [PIX_W-1:0]  back_i,
    output logic [PIX_W-1:0]  mix_o
);
    localparam int PW = 2 * CHAN_W;
    localparam logic [CHAN_W-1:0] FULL = {CHAN_W{1'b1}};

    logic [CHAN_W-1:0] inv_alpha;
    assign inv_alpha = FULL - alpha_i;

    for (genvar g = 0; g < CHAN_N; g++) begin : g_chan
        logic [PW-1:0] prod;
        logic [PW-1:0] scaled;
        assign prod = PW'(alpha_i) * PW'(fore_i[g*CHAN_W +: CHAN_W])
                    + PW'(inv_alpha) * PW'(back_i[g*CHAN_W +: CHAN_W]);
        // exact floor division by the full-scale value, no divider
        assign scaled = prod + PW'(1) + (prod >> CHAN_W);
        assign mix_o[g*CHAN_W +: CHAN_W] = CHAN_W'(scaled >> CHAN_W);
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cur_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int MAX_DIM = 64,
    localparam int DW     = $clog2(MAX_DIM),
    localparam int AW     = 2 * DW,
    localparam int DEPTH  = MAX_DIM * MAX_DIM
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cur_fmt_i,
    input  logic                 cur_big_i,
    input  logic                 cur_pipe_i,
    input  logic [2*COORD_W-1:0] pos_i,
    input  logic [PIX_W-1:0]     fg_i,
    input  logic [PIX_W-1:0]     bg_i,
    input  logic                 img_we_i,
    input  logic [AW-1:0]        img_addr_i,
    input  logic [IMG_W-1:0]     img_data_i,
    input  logic                 pix_vld_i,
    input  logic                 pix_pipe_i,
    input  logic [COORD_W-1:0]   pix_x_i,
    input  logic [COORD_W-1:0]   pix_y_i,
    input  logic [PIX_W-1:0]     pix_base_i,
    output logic                 out_vld_o,
    output logic [PIX_W-1:0]     out_pix_o
);
    ovl_state_t       st_q, st_d;
    logic             in_box;
    logic [AW-1:0]    rd_addr;
    logic [IMG_W-1:0] img_word;
    logic [PIX_W-1:0] blended;
    logic [PIX_W-1:0] mixed;

    cur_hit #(.COORD_W(COORD_W), .MAX_DIM(MAX_DIM)) i_hit (
        .x_i      (pix_x_i),
        .y_i      (pix_y_i),
        .org_x_i  (pos_i[COORD_W-1:0]),
        .org_y_i  (pos_i[2*COORD_W-1:COORD_W]),
        .big_i    (cur_big_i),
        .in_box_o (in_box),
        .addr_o   (rd_addr)
    );

    cur_img_ram #(.WIDTH(IMG_W), .DEPTH(DEPTH)) i_ram (
        .clk     (clk),
        .we_i    (img_we_i),
        .waddr_i (img_addr_i),
        .wdata_i (img_data_i),
        .re_i    (pix_vld_i),
        .raddr_i (rd_addr),
        .rdata_o (img_word)
    );

    cur_blend i_blend (
        .alpha_i (img_word[IMG_W-1 -: CHAN_W]),
        .fore_i  (img_word[PIX_W-1:0]),
        .back_i  (st_q.s1.base),
        .mix_o   (blended)
    );

    always_comb begin
        st_d = st_q;

        st_d.s1.vld  = pix_vld_i;
        st_d.s1.hit  = pix_vld_i && in_box && (pix_pipe_i == cur_pipe_i);
        st_d.s1.fmt  = cur_fmt_e'(cur_fmt_i);
        st_d.s1.base = pix_base_i;
        st_d.s1.fg   = fg_i;
        st_d.s1.bg   = bg_i;

        mixed = st_q.s1.base;
        if (st_q.s1.hit) begin
            unique case (st_q.s1.fmt)
                FMT_MONO: begin
                    if (img_word[1]) begin
                        mixed = img_word[0] ? st_q.s1.fg : st_q.s1.bg;
                    end
                end
                FMT_ARGB: mixed = blended;
                default:  mixed = st_q.s1.base;
            endcase
        end

        st_d.s2.vld = st_q.s1.vld;
        if (st_q.s1.vld) begin
            st_d.s2.pix = mixed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld_o = st_q.s2.vld;
    assign out_pix_o = st_q.s2.pix;
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int PW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cur_fmt_i,
    input logic          cur_pipe_i,
    input logic          pix_vld_i,
    input logic          pix_pipe_i,
    input logic [PW-1:0] pix_base_i,
    input logic          out_vld_o,
    input logic [PW-1:0] out_pix_o
);
    logic [1:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_vld_o && out_pix_o == '0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (out_vld_o == $past(pix_vld_i, 2)));

    // R3
    fmt_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_vld_o &&
         ($past(cur_fmt_i, 2) == 2'd0 || $past(cur_fmt_i, 2) == 2'd3))
        |-> (out_pix_o == $past(pix_base_i, 2)));

    // R4
    other_pipe_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_vld_o && ($past(pix_pipe_i, 2) != $past(cur_pipe_i, 2)))
        |-> (out_pix_o == $past(pix_base_i, 2)));
endmodule

bind cursor_overlay cursor_overlay_chk #(.PW(cur_pkg::PIX_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_fmt_i  (cur_fmt_i),
    .cur_pipe_i (cur_pipe_i),
    .pix_vld_i  (pix_vld_i),
    .pix_pipe_i (pix_pipe_i),
    .pix_base_i (pix_base_i),
    .out_vld_o  (out_vld_o),
    .out_pix_o  (out_pix_o)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_fmt_i = 2'd0;
    logic        cur_big_i = 1'b0;
    logic        cur_pipe_i = 1'b0;
    logic [31:0] pos_i = '0;
    logic [23:0] fg_i = '0;
    logic [23:0] bg_i = '0;
    logic        img_we_i = 1'b0;
    logic [11:0] img_addr_i = '0;
    logic [31:0] img_data_i = '0;
    logic        pix_vld_i = 1'b0;
    logic        pix_pipe_i = 1'b0;
    logic [15:0] pix_x_i = '0;
    logic [15:0] pix_y_i = '0;
    logic [23:0] pix_base_i = '0;
    logic        out_vld_o;
    logic [23:0] out_pix_o;

    cursor_overlay i_cursor_overlay (.*);

    always #2 clk = ~clk;

    logic [31:0] shadow [4096];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic        pend_v = 1'b0;
    logic [23:0] pend_pix = '0;
    string       pend_tag = "R2";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model(input logic pipe, input int x, input int y,
                                          input logic [23:0] base, output string tag);
        int dim, ox, oy, addr, a;
        logic [31:0] w;
        logic [23:0] r;
        dim = cur_big_i ? 64 : 32;
        ox = int'(pos_i[15:0]);
        oy = int'(pos_i[31:16]);
        if (cur_fmt_i == 2'd0 || cur_fmt_i == 2'd3) begin
            tag = "R3"; return base;
        end
        if (pipe != cur_pipe_i) begin
            tag = "R4"; return base;
        end
        if (x < ox || y < oy || x >= ox + dim || y >= oy + dim) begin
            tag = "R5"; return base;
        end
        addr = (y - oy) * dim + (x - ox);
        w = shadow[addr];
        if (cur_fmt_i == 2'd1) begin
            tag = "R7";
            if (!w[1]) return base;
            return w[0] ? fg_i : bg_i;
        end
        tag = "R8";
        a = int'(w[31:24]);
        for (int c = 0; c < 3; c++) begin
            r[c*8 +: 8] = 8'((a * int'(w[c*8 +: 8]) + (255 - a) * int'(base[c*8 +: 8])) / 255);
        end
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
        chk("R2", {31'd0, out_vld_o}, {31'd0, pend_v});
        if (pend_v) chk(pend_tag, {8'd0, out_pix_o}, {8'd0, pend_pix});
    endtask

    task automatic send(input logic pipe, input int x, input int y,
                        input logic [23:0] base, input string over = "");
        string t;
        logic [23:0] e;
        pix_vld_i = 1'b1; pix_pipe_i = pipe;
        pix_x_i = 16'(x); pix_y_i = 16'(y); pix_base_i = base;
        e = model(pipe, x, y, base, t);
        if (over != "") t = over;
        tick();
        pend_v = 1'b1; pend_pix = e; pend_tag = t;
        pix_vld_i = 1'b0;
    endtask

    task automatic idle();
        tick();
        pend_v = 1'b0;
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        img_we_i = 1'b1; img_addr_i = 12'(addr); img_data_i = data;
        tick();
        pend_v = 1'b0;
        shadow[addr] = data;
        img_we_i = 1'b0;
    endtask

    task automatic setup(input logic [1:0] fmt, input logic big, input logic pipe,
                         input int ox, input int oy);
        cur_fmt_i = fmt; cur_big_i = big; cur_pipe_i = pipe;
        pos_i = {16'(oy), 16'(ox)};
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs idle in reset
        chk("R1", {31'd0, out_vld_o}, 32'd0);
        chk("R1", {8'd0, out_pix_o}, 32'd0);
        rst_n = 1'b1;
        idle(); idle();

        for (int i = 0; i < 4096; i++) wr(i, $urandom());
        fg_i = 24'hF0F0F0; bg_i = 24'h0A0B0C;

        // R9: freshly written word used by next pixel
        setup(2'd2, 1'b0, 1'b0, 40, 20);
        wr(0, 32'hFF123456);
        send(1'b0, 40, 20, 24'h777777, "R9");
        // R8: alpha extremes
        wr(1, 32'h00ABCDEF);
        send(1'b0, 41, 20, 24'h314159, "R8");
        wr(2, 32'h80FF0000);
        send(1'b0, 42, 20, 24'h0000FF, "R8");
        // R6: origin fields and row-major indexing, both sizes
        send(1'b0, 40 + 5, 20 + 3, 24'h222222, "R6");
        send(1'b0, 40 + 31, 20 + 31, 24'h333333, "R6");
        setup(2'd2, 1'b1, 1'b0, 40, 20);
        send(1'b0, 40 + 63, 20 + 63, 24'h444444, "R6");
        send(1'b0, 40 + 32, 20 + 1, 24'h555555, "R6");
        // R5: box edges
        send(1'b0, 40 + 64, 20, 24'h666666, "R5");
        send(1'b0, 39, 20, 24'h676767, "R5");
        setup(2'd2, 1'b0, 1'b0, 40, 20);
        send(1'b0, 40 + 32, 20, 24'h686868, "R5");
        send(1'b0, 40, 20 + 32, 24'h696969, "R5");
        // R5: no wrap past the top of the coordinate range
        setup(2'd2, 1'b1, 1'b0, 16'hFFF0, 16'hFFF0);
        send(1'b0, 5, 16'hFFF5, 24'h6A6A6A, "R5");
        send(1'b0, 16'hFFF5, 16'hFFF5, 24'h6B6B6B, "R6");
        // R7: masked format, all three pixel kinds
        setup(2'd1, 1'b0, 1'b1, 0, 0);
        wr(0, 32'h0000_0000);
        wr(1, 32'hFFFF_FFF2);
        wr(2, 32'h0000_0003);
        send(1'b1, 0, 0, 24'h123123, "R7");
        send(1'b1, 1, 0, 24'h123123, "R7");
        send(1'b1, 2, 0, 24'h123123, "R7");
        // R4: other pipe untouched
        send(1'b0, 2, 0, 24'h456456, "R4");
        // R3: off and reserved formats
        setup(2'd0, 1'b0, 1'b1, 0, 0);
        send(1'b1, 2, 0, 24'h789789, "R3");
        setup(2'd3, 1'b0, 1'b1, 0, 0);
        send(1'b1, 2, 0, 24'h89A89A, "R3");
        idle();

        // random bursts
        for (int r = 0; r < 40; r++) begin
            int ox, oy;
            ox = int'($urandom_range(0, 300));
            oy = int'($urandom_range(0, 300));
            setup(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), ox, oy);
            fg_i = 24'($urandom()); bg_i = 24'($urandom());
            for (int p = 0; p < 60; p++) begin
                int x, y;
                logic pp;
                x = ox - 8 + int'($urandom_range(0, 80));
                y = oy - 8 + int'($urandom_range(0, 80));
                if (x < 0) x = 0;
                if (y < 0) y = 0;
                pp = ($urandom_range(0, 9) < 8) ? cur_pipe_i : ~cur_pipe_i;
                if ($urandom_range(0, 7) == 0) idle();
                else send(pp, x, y, 24'($urandom()));
            end
            idle();
        end
        idle();

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule